// File: doc/BRIEF.md
# Peripheral Event Interrupt Controller

This block gathers five single-cycle event pulses from neighbouring peripheral logic (two timer underflows, a time-of-day alarm match, a serial shift register full/empty event and an external edge flag). Each pulse is held in a sticky status bit. The block also has an enable mask. Any held event whose enable bit is set raises a summary bit in the status byte and pulls an active-low interrupt request line.

Software uses one register location for two purposes. Reading it returns the status byte and then clears it. Writing it changes the enable mask. The top data bit of a write chooses whether the ones in the lower bits set enable bits or clear them. Enable bits that match zeros in the written byte are left as they were. A request line shared by several such blocks can therefore be serviced by polling the summary bit, or by taking the interrupt directly.

Top module: `evt_irq_unit`

## Requirements
- R1: The status byte places the sources by bit: bit 0 timer A underflow, bit 1 timer B underflow, bit 2 time-of-day alarm, bit 3 serial full/empty, bit 4 external flag. Bit 7 is the summary (IR) bit, and bits 6:5 always read 0.
- R2: A pulse on any `evtPulse` bit sets the matching status bit on the next clock edge, whatever the mask holds. The bit stays set until the status byte is read.
- R3: One clock after any latched status bit has its mask bit set, status bit 7 reads 1 and `irqN` is low. When no latched bit is enabled, bit 7 reads 0 and `irqN` is high one clock later. This includes the case where a mask bit is cleared.
- R4: A read access (`chipSel` and `rdStb` high) drives the status byte onto `rdData` in that cycle. At that clock edge every status bit, including IR, is cleared, and `irqN` returns high.
- R5: An event pulse in the same cycle as a read is not part of the byte returned. It is latched after the clear and appears on the next read.
- R6: A write access (`chipSel` and `wrStb` high) with `wrData[7]`=1 sets every mask bit whose data bit in 4:0 is 1.
- R7: A write access with `wrData[7]`=0 clears every mask bit whose data bit in 4:0 is 1.
- R8: In both write modes, mask bits whose data bit is 0 keep their value. For example, 0x7E followed by 0x81 leaves only timer A enabled.
- R9: Mask positions 5 and 6 hold no state. Writing ones to them has no effect on `irqN` or on the status byte.
- R10: After reset the mask and status are all zero and `irqN` is high.
- R11: `rdData` is 0x00 in any cycle without a read access.
- R12: `rdStb` or `wrStb` without `chipSel` changes neither status nor mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipSel | input | 1 | Register access select |
| rdStb | input | 1 | Read strobe, one cycle per access |
| wrStb | input | 1 | Write strobe, one cycle per access |
| wrData | input | 8 | Write byte: bit 7 selects set or clear, bits 4:0 select mask bits |
| rdData | output | 8 | Status byte during a read, 0x00 otherwise |
| evtPulse | input | 5 | One-cycle event pulses, one per source |
| irqN | output | 1 | Active-low interrupt request |

## Verification
A wrong mask bit shows up as an `irqN` level that is wrong one clock after the next event on that source. It also shows up as a wrong bit 7 on the following read. A status bit that was lost or left stuck shows up in the byte of the next read access. For that reason every scenario closes with a read, or with a check of `irqN` one cycle after each operation. A defect in the clear-then-latch ordering shows up only on the second of two back-to-back reads, so the bench issues reads in pairs around coincident events.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned SUM_POS = BYTE_W - 1;
  localparam int unsigned PAD_W   = SUM_POS - NUM_SRC;

  typedef struct packed {
    logic readClr;  // status byte is read this cycle, clear at edge
    logic maskLd;   // mask update this cycle
    logic setMode;  // 1: ones set mask bits, 0: ones clear them
  } ctrlStb_t;
endpackage

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          chipSel,
  input  logic          rdStb,
  input  logic          wrStb,
  input  logic [DW-1:0] wrData,
  output ctrlStb_t      stb
);
  localparam int unsigned MODE_BIT = DW - 1;

  always_comb begin
    stb.readClr = chipSel & rdStb;
    stb.maskLd  = chipSel & wrStb;
    stb.setMode = wrData[MODE_BIT];
  end
endmodule

// File: rtl/evt_irq_datapath.sv
module evt_irq_datapath
  import evt_irq_pkg::*;
#(
  parameter int unsigned NS = NUM_SRC,
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStb_t      stb,
  input  logic [DW-1:0] wrData,
  input  logic [NS-1:0] evtPulse,
  output logic [DW-1:0] statusByte,
  output logic [NS-1:0] maskBits,
  output logic [DW-1:0] rdData,
  output logic          irqN
);
  localparam int unsigned PADW = DW - 1 - NS;

  logic [NS-1:0] flagQ, flagD;
  logic [NS-1:0] maskQ, maskD;
  logic          sumQ, sumD;
  logic          irqNQ;

  // per-source slices: flag and mask update
  for (genvar k = 0; k < NS; k++) begin : g_src
    always_comb begin
      // clear on read first, then any coincident event re-sets the flag
      flagD[k] = (stb.readClr ? 1'b0 : flagQ[k]) | evtPulse[k];
      maskD[k] = maskQ[k];
      if (stb.maskLd && wrData[k]) begin
        maskD[k] = stb.setMode;
      end
    end
  end

  always_comb begin
    sumD = |(flagD & maskD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      maskQ <= '0;
      sumQ  <= 1'b0;
      irqNQ <= 1'b1;
    end else begin
      flagQ <= flagD;
      maskQ <= maskD;
      sumQ  <= sumD;
      irqNQ <= ~sumD;
    end
  end

  always_comb begin
    statusByte = {sumQ, {PADW{1'b0}}, flagQ};
    rdData     = stb.readClr ? statusByte : '0;
  end

  assign maskBits = maskQ;
  assign irqN     = irqNQ;
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               chipSel,
  input  logic               rdStb,
  input  logic               wrStb,
  input  logic [BYTE_W-1:0]  wrData,
  output logic [BYTE_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] evtPulse,
  output logic               irqN
);
  ctrlStb_t             stb;
  logic [BYTE_W-1:0]    statusByte;
  logic [NUM_SRC-1:0]   maskBits;

  evt_irq_ctrl #(.DW(BYTE_W)) ctrl_i (
    .chipSel (chipSel),
    .rdStb   (rdStb),
    .wrStb   (wrStb),
    .wrData  (wrData),
    .stb     (stb)
  );

  evt_irq_datapath #(.NS(NUM_SRC), .DW(BYTE_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .evtPulse   (evtPulse),
    .statusByte (statusByte),
    .maskBits   (maskBits),
    .rdData     (rdData),
    .irqN       (irqN)
  );
endmodule

// File: rtl/evt_irq_checker.sv
module evt_irq_checker
  import evt_irq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               chipSel,
  input logic               rdStb,
  input logic               wrStb,
  input logic [BYTE_W-1:0]  wrData,
  input logic [NUM_SRC-1:0] evtPulse,
  input logic [BYTE_W-1:0]  statusByte,
  input logic [NUM_SRC-1:0] maskBits,
  input logic               irqN
);
  logic rdAct, wrAct;
  assign rdAct = chipSel & rdStb;
  assign wrAct = chipSel & wrStb;

  assert_evt_latched_R2: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((statusByte[NUM_SRC-1:0] & $past(evtPulse)) == $past(evtPulse)));

  assert_enabled_irq_R3: assert property (@(posedge clk) disable iff (!rstN)
    (((statusByte[NUM_SRC-1:0] & maskBits) != '0) && !rdAct && !wrAct) |=> !irqN);

  assert_read_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdAct && evtPulse == '0) |=> (irqN && statusByte == '0));

  assert_mask_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrAct && wrData[SUM_POS]) |=>
      ((maskBits & $past(wrData[NUM_SRC-1:0])) == $past(wrData[NUM_SRC-1:0])));

  assert_mask_clr_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrAct && !wrData[SUM_POS]) |=> ((maskBits & $past(wrData[NUM_SRC-1:0])) == '0));

  assert_mask_keep_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrAct |=> ((maskBits & ~$past(wrData[NUM_SRC-1:0])) ==
               ($past(maskBits) & ~$past(wrData[NUM_SRC-1:0]))));

  assert_pad_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[SUM_POS-1:NUM_SRC] == '0);

  assert_no_cs_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSel && evtPulse == '0) |=> ($stable(maskBits) && $stable(statusByte[NUM_SRC-1:0])));
endmodule

bind evt_irq_unit evt_irq_checker chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .chipSel    (chipSel),
  .rdStb      (rdStb),
  .wrStb      (wrStb),
  .wrData     (wrData),
  .evtPulse   (evtPulse),
  .statusByte (statusByte),
  .maskBits   (maskBits),
  .irqN       (irqN)
);

// File: tb/evt_irq_unit_tb.sv
module evt_irq_unit_tb_top;
  localparam int PERIOD = 10;
  localparam int WATCHDOG_CYC = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chipSel = 1'b0, rdStb = 1'b0, wrStb = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [4:0] evtPulse = 5'h00;
  logic       irqN;

  int nVec = 0, nBad = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] expByte; string req; } item_t;
  item_t sbQ[$];

  logic [4:0] mFlags = '0, mMask = '0;
  logic       mIr = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  evt_irq_unit dut_i (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .rdData(rdData), .evtPulse(evtPulse), .irqN(irqN)
  );

  // monitor: compares read bytes against queued expectations
  always begin
    @(negedge clk);
    #1;
    if (chipSel && rdStb) begin
      nVec++;
      if (sbQ.size() == 0) begin
        nBad++;
        $display("FAIL R4 unexpected read: actual %h expected none", rdData);
      end else begin
        item_t it;
        it = sbQ.pop_front();
        if (rdData !== it.expByte) begin
          nBad++;
          $display("FAIL %s rdData actual %h expected %h", it.req, rdData, it.expByte);
        end
      end
    end
  end

  task automatic op(input logic [4:0] ev, input bit cs, input bit rd, input bit wr,
                    input logic [7:0] wd, input string req);
    item_t it;
    @(negedge clk);
    chipSel = cs; rdStb = rd; wrStb = wr; wrData = wd; evtPulse = ev;
    if (cs && rd) begin
      it.expByte = {mIr, 2'b00, mFlags};
      it.req = req;
      sbQ.push_back(it);
    end
    // model from requirements
    if (cs && rd) mFlags = '0;
    mFlags = mFlags | ev;
    if (cs && wr) begin
      if (wd[7]) mMask = mMask | wd[4:0];
      else       mMask = mMask & ~wd[4:0];
    end
    mIr = |(mFlags & mMask);
    #1;
    if (!(cs && rd)) begin
      nVec++;
      if (rdData !== 8'h00) begin
        nBad++;
        $display("FAIL R11 %s idle rdData actual %h expected 00", req, rdData);
      end
    end
    @(negedge clk);
    chipSel = 0; rdStb = 0; wrStb = 0; wrData = 8'h00; evtPulse = '0;
    #2;
    nVec++;
    if (irqN !== !mIr) begin
      nBad++;
      $display("FAIL %s irqN actual %b expected %b", req, irqN, !mIr);
    end
  endtask

  task automatic rd(input string req);  op(5'h00, 1, 1, 0, 8'h00, req); endtask
  task automatic wr(input logic [7:0] d, input string req); op(5'h00, 1, 0, 1, d, req); endtask
  task automatic ev(input logic [4:0] e, input string req); op(e, 0, 0, 0, 8'h00, req); endtask

  initial begin
    repeat (3) @(negedge clk);
    nVec++;
    if (irqN !== 1'b1) begin nBad++; $display("FAIL R10 irqN in reset actual %b expected 1", irqN); end
    rstN = 1'b1;
    rd("R10");                         // 00 after reset
    ev(5'h1F, "R2");                   // all sources, mask empty
    rd("R1_R2");                       // expect 1F, IR 0
    rd("R4");                          // cleared: 00
    wr(8'h81, "R6");                   // enable timer A
    ev(5'h01, "R3");                   // irq low
    rd("R3_R4");                       // expect 81, irq high after
    ev(5'h02, "R2");                   // timer B not enabled
    rd("R2");                          // expect 02
    wr(8'h9F, "R6");                   // all enabled
    wr(8'h7E, "R7_R8");                // only timer A left
    ev(5'h02, "R8");                   // irq stays high
    ev(5'h01, "R8");                   // irq low
    rd("R8");                          // expect 83
    ev(5'h10, "R2");                   // flag (disabled)
    op(5'h04, 1, 1, 0, 8'h00, "R5");   // read 10 while alarm arrives
    rd("R5");                          // expect 04 kept
    ev(5'h08, "R3");                   // serial latched, disabled
    wr(8'h88, "R3");                   // enable serial -> irq low
    wr(8'h08, "R3");                   // disable -> irq high
    wr(8'hE0, "R9");                   // set pad bits: no effect
    rd("R9");                          // expect 08, pad bits 0
    ev(5'h01, "R3");                   // timer A still enabled
    op(5'h00, 0, 1, 0, 8'h00, "R12");  // read strobe without select
    op(5'h00, 0, 0, 1, 8'h01, "R12");  // clear timer A without select: ignored
    rd("R12");                         // expect 81
    wr(8'h01, "R7");                   // clear timer A
    ev(5'h01, "R7");                   // irq stays high
    rd("R7");                          // expect 01
    repeat (2) @(negedge clk);
    nVec++;
    if (sbQ.size() != 0) begin nBad++; $display("FAIL R4 pending reads actual %0d expected 0", sbQ.size()); end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nBad++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule